// File: doc/BRIEF.md
# Split-Byte Register File

This block is the architectural register file of a 16-bit processor datapath. It holds eight 16-bit registers in two groups. Selects 0 to 3 are the general-purpose group: accumulator, base, count and data. Any of these can be read or written as a whole word, or as its high byte or its low byte on its own. Selects 4 to 7 are the pointer group: stack pointer, base pointer, source index and destination index. These allow whole-word access only.

There are two combinational read ports and one write port. Each port has a register select and a 2-bit access size. A write takes effect at the rising clock edge. A read in the same cycle still returns the old contents.

A separate 16-bit status word holds nine single-bit flags at fixed positions. It can be loaded as a whole word. Any chosen set of its flags can also be forced to given values in the same cycle, so an execution stage can post only the flags that an operation changes.

Top module: `split_byte_regfile`

## Requirements
- R1: While rst_ni is low, all eight registers and the status word are cleared, so every read returns 0 and flags_o is 0.
- R2: A write with size 00 (word) to any select 0..7 stores all 16 bits of wr_data_i. A size-00 read returns the full register.
- R3: A write with size 01 (low byte) to select 0..3 loads wr_data_i[7:0] into bits 7:0 and leaves bits 15:8 of that register unchanged.
- R4: A write with size 10 (high byte) to select 0..3 loads wr_data_i[7:0] into bits 15:8 and leaves bits 7:0 unchanged.
- R5: A read with size 01 returns {8'h00, bits 7:0}. A read with size 10 returns {8'h00, bits 15:8}. Both apply to selects 0..3.
- R6: Size 01 or 10 on selects 4..7, or size 11 on any select, is illegal. The matching illegal output is high, a read returns 0, and a write (with wr_en_i high) changes no register.
- R7: The two read ports decode their select and size independently of each other, in the same cycle.
- R8: In the status word only bits 11, 10, 9, 8, 7, 6, 4, 2 and 0 hold state (mask 16'h0FD5). The other seven bits always read 0, and writes to them are ignored.
- R9: flags_wr_i loads flags_wdata_i. Each bit set in flags_upd_mask_i forces that flag to the matching bit of flags_upd_val_i, and this overrides a word load in the same cycle.
- R10: With wr_en_i low, no register changes. With flags_wr_i low and flags_upd_mask_i zero, the status word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write request |
| wr_sel_i | input | 3 | Write register select |
| wr_size_i | input | 2 | Write access size (00 word, 01 low, 10 high) |
| wr_data_i | input | 16 | Write data; a byte write uses bits 7:0 |
| wr_illegal_o | output | 1 | Write request is illegal |
| rd0_sel_i | input | 3 | Read port 0 select |
| rd0_size_i | input | 2 | Read port 0 access size |
| rd0_data_o | output | 16 | Read port 0 data |
| rd0_illegal_o | output | 1 | Read port 0 access is illegal |
| rd1_sel_i | input | 3 | Read port 1 select |
| rd1_size_i | input | 2 | Read port 1 access size |
| rd1_data_o | output | 16 | Read port 1 data |
| rd1_illegal_o | output | 1 | Read port 1 access is illegal |
| flags_wr_i | input | 1 | Load the whole status word |
| flags_wdata_i | input | 16 | Status word load value |
| flags_upd_mask_i | input | 16 | Per-flag update enables |
| flags_upd_val_i | input | 16 | Per-flag update values |
| flags_o | output | 16 | Status word |

## Verification
Every register is first loaded with a distinct word. Byte writes of every size then go to every select. After each write, all eight registers are read at all four sizes on both ports, with port 1 offset in select and size. This separates lost or crossed byte lanes, halves that are not kept, a legal group boundary in the wrong place, and port crosstalk. The status word is tried with all-ones, all-zero and alternating word loads, with single-bit updates across all sixteen positions, and with a word load and an update in the same cycle. These patterns expose stored unused bits, a misplaced flag mask and the wrong update priority.

// File: rtl/sbrf_pkg.sv
package sbrf_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_LO   = 2'b01,
    SZ_HI   = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  function automatic logic acc_legal(input acc_size_e sz, input logic is_gp);
    return (sz == SZ_WORD) || (is_gp && (sz == SZ_LO || sz == SZ_HI));
  endfunction
endpackage

// File: rtl/sbrf_bank.sv
module sbrf_bank
  import sbrf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_GP   = 4,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [SEL_W-1:0]                 wr_sel_i,
  input  acc_size_e                        wr_size_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic                             wr_illegal_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic                is_gp;
  logic                legal;
  logic [NUM_REGS-1:0] we_lo;
  logic [NUM_REGS-1:0] we_hi;
  logic [BYTE_W-1:0]   hi_src;

  assign is_gp        = ({1'b0, wr_sel_i} < (SEL_W+1)'(NUM_GP));
  assign legal        = acc_legal(wr_size_i, is_gp);
  assign wr_illegal_o = wr_en_i && !legal;
  // high-byte writes take the byte from the low lane
  assign hi_src = (wr_size_i == SZ_HI) ? wr_data_i[BYTE_W-1:0] : wr_data_i[DATA_W-1:BYTE_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit      = wr_en_i && legal && (wr_sel_i == SEL_W'(i));
    assign we_lo[i] = hit && (wr_size_i == SZ_WORD || wr_size_i == SZ_LO);
    assign we_hi[i] = hit && (wr_size_i == SZ_WORD || wr_size_i == SZ_HI);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[i] <= '0;
      end else begin
        if (we_lo[i]) regs_o[i][BYTE_W-1:0]      <= wr_data_i[BYTE_W-1:0];
        if (we_hi[i]) regs_o[i][DATA_W-1:BYTE_W] <= hi_src;
      end
    end

    assert_low_keeps_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_lo[i] && !we_hi[i]) |=> $stable(regs_o[i][DATA_W-1:BYTE_W]));
    assert_high_keeps_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_hi[i] && !we_lo[i]) |=> $stable(regs_o[i][BYTE_W-1:0]));
    if (i >= NUM_GP) begin : g_ptr_chk
      assert_ptr_word_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_lo[i] == we_hi[i]);
    end
  end
endmodule

// File: rtl/sbrf_rd_port.sv
module sbrf_rd_port
  import sbrf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_GP   = 4,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = 3
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  acc_size_e                       size_i,
  output logic [DATA_W-1:0]               data_o,
  output logic                            illegal_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic              is_gp;
  logic [DATA_W-1:0] word;

  assign is_gp     = ({1'b0, sel_i} < (SEL_W+1)'(NUM_GP));
  assign illegal_o = !acc_legal(size_i, is_gp);
  assign word      = regs_i[sel_i];

  always_comb begin
    data_o = '0;
    if (!illegal_o) begin
      unique case (size_i)
        SZ_WORD: data_o = word;
        SZ_LO:   data_o = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
        SZ_HI:   data_o = {{BYTE_W{1'b0}}, word[DATA_W-1:BYTE_W]};
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sbrf_flags.sv
module sbrf_flags #(
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] FLAG_MASK = 16'h0FD5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] upd_mask_i,
  input  logic [DATA_W-1:0] upd_val_i,
  output logic [DATA_W-1:0] flags_o
);
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nxt;

  assign base = wr_i ? wdata_i : flags_o;
  // per-flag update wins over a word load
  assign nxt  = ((base & ~upd_mask_i) | (upd_val_i & upd_mask_i)) & FLAG_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= nxt;
  end

  assert_unused_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || |upd_mask_i) |=> ((flags_o & ~FLAG_MASK) == '0));
  assert_update_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd_mask_i) |=> (((flags_o ^ $past(upd_val_i)) & $past(upd_mask_i) & FLAG_MASK) == '0));
  assert_flags_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && upd_mask_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/split_byte_regfile.sv
module split_byte_regfile
  import sbrf_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                NUM_GP    = 4,
  parameter int                NUM_PTR   = 4,
  parameter int                SEL_W     = $clog2(NUM_GP + NUM_PTR),
  parameter logic [DATA_W-1:0] FLAG_MASK = 16'h0FD5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [1:0]        wr_size_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_illegal_o,
  input  logic [SEL_W-1:0]  rd0_sel_i,
  input  logic [1:0]        rd0_size_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic              rd0_illegal_o,
  input  logic [SEL_W-1:0]  rd1_sel_i,
  input  logic [1:0]        rd1_size_i,
  output logic [DATA_W-1:0] rd1_data_o,
  output logic              rd1_illegal_o,
  input  logic              flags_wr_i,
  input  logic [DATA_W-1:0] flags_wdata_i,
  input  logic [DATA_W-1:0] flags_upd_mask_i,
  input  logic [DATA_W-1:0] flags_upd_val_i,
  output logic [DATA_W-1:0] flags_o
);
  localparam int NUM_REGS = NUM_GP + NUM_PTR;
  localparam int BYTE_W   = DATA_W / 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  sbrf_bank #(
    .DATA_W(DATA_W), .NUM_GP(NUM_GP), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_size_i   (acc_size_e'(wr_size_i)),
    .wr_data_i   (wr_data_i),
    .wr_illegal_o(wr_illegal_o),
    .regs_o      (regs_q)
  );

  sbrf_rd_port #(
    .DATA_W(DATA_W), .NUM_GP(NUM_GP), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) i_rd0 (
    .regs_i   (regs_q),
    .sel_i    (rd0_sel_i),
    .size_i   (acc_size_e'(rd0_size_i)),
    .data_o   (rd0_data_o),
    .illegal_o(rd0_illegal_o)
  );

  sbrf_rd_port #(
    .DATA_W(DATA_W), .NUM_GP(NUM_GP), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
  ) i_rd1 (
    .regs_i   (regs_q),
    .sel_i    (rd1_sel_i),
    .size_i   (acc_size_e'(rd1_size_i)),
    .data_o   (rd1_data_o),
    .illegal_o(rd1_illegal_o)
  );

  sbrf_flags #(
    .DATA_W(DATA_W), .FLAG_MASK(FLAG_MASK)
  ) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (flags_wr_i),
    .wdata_i   (flags_wdata_i),
    .upd_mask_i(flags_upd_mask_i),
    .upd_val_i (flags_upd_val_i),
    .flags_o   (flags_o)
  );

  assert_word_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_size_i == 2'b00) |=> (regs_q[$past(wr_sel_i)] == $past(wr_data_i)));
  assert_illegal_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o |=> $stable(regs_q));
  assert_idle_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
  assert_byte_read_zext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_size_i inside {2'b01, 2'b10}) |-> (rd0_data_o[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/test_split_byte_regfile.sv
module test_split_byte_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FMASK = 16'((1 << 11) | (1 << 10) | (1 << 9) | (1 << 8) |
                                      (1 << 7) | (1 << 6) | (1 << 4) | (1 << 2) | 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [1:0]  wr_size = '0;
  logic [15:0] wr_data = '0;
  logic        wr_illegal;
  logic [2:0]  rd0_sel = '0, rd1_sel = '0;
  logic [1:0]  rd0_size = '0, rd1_size = '0;
  logic [15:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;
  logic        f_wr = 1'b0;
  logic [15:0] f_wdata = '0, f_mask = '0, f_val = '0;
  logic [15:0] flags;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];
  logic [15:0] mflags;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_byte_regfile i_split_byte_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_size_i(wr_size), .wr_data_i(wr_data),
    .wr_illegal_o(wr_illegal),
    .rd0_sel_i(rd0_sel), .rd0_size_i(rd0_size), .rd0_data_o(rd0_data), .rd0_illegal_o(rd0_illegal),
    .rd1_sel_i(rd1_sel), .rd1_size_i(rd1_size), .rd1_data_o(rd1_data), .rd1_illegal_o(rd1_illegal),
    .flags_wr_i(f_wr), .flags_wdata_i(f_wdata), .flags_upd_mask_i(f_mask),
    .flags_upd_val_i(f_val), .flags_o(flags)
  );

  function automatic logic legal(input int sel, input int size);
    return (size == 0) || ((size == 1 || size == 2) && sel < 4);
  endfunction

  function automatic logic [15:0] exp_read(input int sel, input int size);
    if (!legal(sel, size)) return 16'h0;
    if (size == 0) return model[sel];
    if (size == 1) return {8'h00, model[sel][7:0]};
    return {8'h00, model[sel][15:8]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R2 R5 R6 R7: sweep both ports over every select and size
  task automatic read_all(input string req);
    for (int s = 0; s < 8; s++) begin
      for (int z = 0; z < 4; z++) begin
        rd0_sel = 3'(s); rd0_size = 2'(z);
        rd1_sel = 3'((s + 3) % 8); rd1_size = 2'((z + 1) % 4);
        #1;
        check({req, " rd0"}, rd0_data, exp_read(s, z));
        check("R6 rd0 illegal", 16'(rd0_illegal), 16'(!legal(s, z)));
        check("R7 rd1", rd1_data, exp_read((s + 3) % 8, (z + 1) % 4));
        check("R6 rd1 illegal", 16'(rd1_illegal), 16'(!legal((s + 3) % 8, (z + 1) % 4)));
      end
    end
  endtask

  task automatic do_write(input int sel, input int size, input logic [15:0] d, input logic en);
    wr_en = en; wr_sel = 3'(sel); wr_size = 2'(size); wr_data = d;
    #1;
    check("R6 wr_illegal", 16'(wr_illegal), 16'(en && !legal(sel, size)));
    tick();
    wr_en = 1'b0;
    if (en && legal(sel, size)) begin
      if (size == 0) model[sel] = d;
      else if (size == 1) model[sel][7:0] = d[7:0];   // R3
      else model[sel][15:8] = d[7:0];                  // R4
    end
  endtask

  task automatic flag_op(input logic w, input logic [15:0] wd, input logic [15:0] m,
                         input logic [15:0] v, input string req);
    f_wr = w; f_wdata = wd; f_mask = m; f_val = v;
    tick();
    f_wr = 1'b0; f_mask = '0;
    mflags = (((w ? wd : mflags) & ~m) | (v & m)) & FMASK;
    check(req, flags, mflags);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    mflags = '0;
    repeat (3) tick();
    // R1 reset state
    read_all("R1");
    check("R1 flags", flags, 16'h0);
    rst_n = 1'b1;
    tick();

    // R2 word writes to every register
    for (int r = 0; r < 8; r++) do_write(r, 0, 16'(16'h1357 * (r + 1)) ^ 16'hA5C3, 1'b1);
    read_all("R2");

    // R3 R4 R6 byte writes of every size to every select
    for (int r = 0; r < 8; r++) begin
      for (int z = 1; z < 4; z++) begin
        do_write(r, z, 16'h3C00 | 16'((r * 37 + z * 11) & 8'hFF), 1'b1);
        read_all(z == 1 ? "R3" : (z == 2 ? "R4" : "R6"));
      end
    end

    // R10 disabled writes
    for (int r = 0; r < 8; r++) do_write(r, 0, 16'hDEAD, 1'b0);
    read_all("R10");

    // R8 R9 status word
    flag_op(1'b1, 16'hFFFF, 16'h0, 16'h0, "R8 all-ones");
    flag_op(1'b1, 16'hA5A5, 16'h0, 16'h0, "R8 A5A5");
    flag_op(1'b1, 16'h5A5A, 16'h0, 16'h0, "R8 5A5A");
    flag_op(1'b1, 16'h0000, 16'h0, 16'h0, "R8 zero");
    for (int b = 0; b < 16; b++) flag_op(1'b0, 16'h0, 16'(1 << b), 16'hFFFF, "R9 set bit");
    for (int b = 0; b < 16; b += 2) flag_op(1'b0, 16'h0, 16'(1 << b), 16'h0, "R9 clear bit");
    flag_op(1'b1, 16'hFFFF, 16'h00F0, 16'h0000, "R9 update over load");
    flag_op(1'b1, 16'h0000, 16'h0F00, 16'hFFFF, "R9 update over load 2");
    flag_op(1'b0, 16'h1234, 16'h0, 16'hFFFF, "R10 flags hold");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule